// File: doc/BRIEF.md
# DRAM Bank Row and Timing Tracker

This block follows the life of a single DRAM bank on behalf of a command scheduler. It records whether a row is open and which row it is. It also counts down the minimum spacings that the bank must respect between commands. Each cycle it answers four questions: may an ACTIVATE, a READ, a WRITE or a PRECHARGE be issued at the next clock edge? The scheduler signals the commands it actually issues with one strobe per command type, and an ACTIVATE also carries the row address.

Each spacing rule has its own down-counter, and a command is legal once its counter has drained to zero. A command that imposes a new spacing reloads the affected counter with the larger of the remaining wait and the new wait, so the tightest earlier constraint is never shortened. The tracker also counts column accesses to the open row. Once a fixed cap is reached it raises a close request, so a long run of hits cannot keep the page open indefinitely. Protocol misuse raises a sticky error flag and is otherwise ignored: this covers opening an already open bank, and reading or writing a closed one.

Top module: `bank_state_tracker`

## Requirements
- R1: After reset the bank is closed. actOk is 1. rdOk, wrOk, preOk, closeReq and protoErr are 0.
- R2: An ACTIVATE taken at edge E while the bank is closed makes rowOpen 1 and openRow equal to the row address sampled at E, both visible after E.
- R3: After an ACTIVATE at edge E, rdOk and wrOk stay 0 until the first edge at which a column command may be issued, which is E+T_RCD (11).
- R4: preOk first allows a PRECHARGE at the latest of three edges: E+T_RAS (28) after the ACTIVATE at E, R+T_RTP (6) after any READ at R, and W+T_BURST+T_WR (16) after any WRITE at W.
- R5: A PRECHARGE at edge P on an open bank closes it. actOk then stays 0 until an ACTIVATE may be issued at edge P+T_RP (11).
- R6: After a READ or WRITE at edge C, the next column command may not be issued before edge C+T_BURST (4).
- R7: closeReq is 1 while the bank is open and 16 (MAX_ACC) or more READs and WRITEs have been taken since the last ACTIVATE. An ACTIVATE restarts the count, and a PRECHARGE drops closeReq.
- R8: An ACTIVATE to an open bank, or a READ or WRITE to a closed bank, sets protoErr, which stays 1 until reset. The offending command changes neither rowOpen nor openRow.
- R9: A PRECHARGE to a closed bank has no effect. The bank stays closed, actOk keeps its value and protoErr is not set.
- R10: When several strobes are high in one cycle, only one acts, chosen in the order ACTIVATE, PRECHARGE, READ, WRITE. The others are dropped without raising protoErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| actIssue | input | 1 | ACTIVATE issued this cycle |
| rdIssue | input | 1 | READ issued this cycle |
| wrIssue | input | 1 | WRITE issued this cycle |
| preIssue | input | 1 | PRECHARGE issued this cycle |
| rowAddr | input | ROW_W | Row address carried by an ACTIVATE |
| rowOpen | output | 1 | A row is open in the bank |
| openRow | output | ROW_W | Address of the open row |
| actOk | output | 1 | ACTIVATE legal at the next edge |
| rdOk | output | 1 | READ legal at the next edge |
| wrOk | output | 1 | WRITE legal at the next edge |
| preOk | output | 1 | PRECHARGE legal at the next edge |
| closeReq | output | 1 | Access cap reached, close the row |
| protoErr | output | 1 | Sticky protocol-error flag |

## Verification
A command sampled at edge E updates rowOpen, openRow, closeReq and protoErr in the same edge. The bench therefore compares them at the falling edge that follows E. A legality flag for a wait of N cycles is 0 at every falling edge from E up to E+N-2, and it reads 1 at the falling edge after E+N-1, just ahead of edge E+N. The bench model stores, for each command type, the absolute edge number from which that command becomes legal. Every falling edge it compares all outputs with those edge numbers. This catches a flag that rises one cycle early or one cycle late.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

  // One-hot effect strobes from the control to the timing datapath
  typedef struct packed {
    logic doAct;
    logic doRd;
    logic doWr;
    logic doPre;
  } bankStrobeT;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadVal,
  output logic             ready
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    dec = (cnt == '0) ? '0 : cnt - 1'b1;
    nxt = (loadEn && (loadVal > dec)) ? loadVal : dec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else       cnt <= nxt;
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/bank_timing_dp.sv
module bank_timing_dp
  import bank_trk_pkg::*;
#(
  parameter int T_RCD   = 11,
  parameter int T_RAS   = 28,
  parameter int T_RP    = 11,
  parameter int T_RTP   = 6,
  parameter int T_WR    = 12,
  parameter int T_BURST = 4,
  parameter int CNT_W   = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  bankStrobeT stb,
  output logic       colReady,
  output logic       preReady,
  output logic       actReady
);
  localparam int NUM_TMR = 3;
  localparam int TMR_COL = 0;
  localparam int TMR_PRE = 1;
  localparam int TMR_ACT = 2;

  localparam logic [CNT_W-1:0] LD_RCD   = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_RAS   = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] LD_RP    = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RTP   = CNT_W'(T_RTP - 1);
  localparam logic [CNT_W-1:0] LD_BURST = CNT_W'(T_BURST - 1);
  localparam logic [CNT_W-1:0] LD_WREC  = CNT_W'(T_BURST + T_WR - 1);

  logic [NUM_TMR-1:0] ld;
  logic [CNT_W-1:0]   lv [NUM_TMR];
  logic [NUM_TMR-1:0] rdy;

  always_comb begin
    ld[TMR_COL] = stb.doAct | stb.doRd | stb.doWr;
    lv[TMR_COL] = stb.doAct ? LD_RCD : LD_BURST;
    ld[TMR_PRE] = stb.doAct | stb.doRd | stb.doWr;
    lv[TMR_PRE] = stb.doAct ? LD_RAS : (stb.doRd ? LD_RTP : LD_WREC);
    ld[TMR_ACT] = stb.doPre;
    lv[TMR_ACT] = LD_RP;
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : gTmr
    bank_timer #(.CNT_W(CNT_W)) uTmr (
      .clk    (clk),
      .rstN   (rstN),
      .loadEn (ld[g]),
      .loadVal(lv[g]),
      .ready  (rdy[g])
    );
  end

  assign colReady = rdy[TMR_COL];
  assign preReady = rdy[TMR_PRE];
  assign actReady = rdy[TMR_ACT];
endmodule

// File: rtl/bank_row_ctrl.sv
module bank_row_ctrl
  import bank_trk_pkg::*;
#(
  parameter int ROW_W   = 16,
  parameter int MAX_ACC = 16,
  parameter int ACC_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             actIssue,
  input  logic             rdIssue,
  input  logic             wrIssue,
  input  logic             preIssue,
  input  logic [ROW_W-1:0] rowAddr,
  input  logic             colReady,
  input  logic             preReady,
  input  logic             actReady,
  output bankStrobeT       stb,
  output logic             rowOpen,
  output logic [ROW_W-1:0] openRow,
  output logic             actOk,
  output logic             rdOk,
  output logic             wrOk,
  output logic             preOk,
  output logic             closeReq,
  output logic             protoErr
);
  localparam logic [ACC_W-1:0] ACC_CAP = ACC_W'(MAX_ACC);

  logic             errNow;
  logic [ACC_W-1:0] accCnt;

  // Priority decode: ACTIVATE, PRECHARGE, READ, WRITE
  always_comb begin
    stb    = '0;
    errNow = 1'b0;
    if (actIssue) begin
      if (rowOpen) errNow = 1'b1;
      else         stb.doAct = 1'b1;
    end else if (preIssue) begin
      stb.doPre = rowOpen;
    end else if (rdIssue) begin
      if (rowOpen) stb.doRd = 1'b1;
      else         errNow = 1'b1;
    end else if (wrIssue) begin
      if (rowOpen) stb.doWr = 1'b1;
      else         errNow = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowOpen  <= 1'b0;
      openRow  <= '0;
      accCnt   <= '0;
      protoErr <= 1'b0;
    end else begin
      if (stb.doAct) begin
        rowOpen <= 1'b1;
        openRow <= rowAddr;
        accCnt  <= '0;
      end else if (stb.doPre) begin
        rowOpen <= 1'b0;
      end else if ((stb.doRd || stb.doWr) && (accCnt != ACC_CAP)) begin
        accCnt <= accCnt + 1'b1;
      end
      if (errNow) protoErr <= 1'b1;
    end
  end

  assign actOk    = !rowOpen && actReady;
  assign rdOk     = rowOpen && colReady;
  assign wrOk     = rowOpen && colReady;
  assign preOk    = rowOpen && preReady;
  assign closeReq = rowOpen && (accCnt == ACC_CAP);
endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
  import bank_trk_pkg::*;
#(
  parameter int ROW_W   = 16,
  parameter int T_RCD   = 11,
  parameter int T_RAS   = 28,
  parameter int T_RP    = 11,
  parameter int T_RTP   = 6,
  parameter int T_WR    = 12,
  parameter int T_BURST = 4,
  parameter int MAX_ACC = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             actIssue,
  input  logic             rdIssue,
  input  logic             wrIssue,
  input  logic             preIssue,
  input  logic [ROW_W-1:0] rowAddr,
  output logic             rowOpen,
  output logic [ROW_W-1:0] openRow,
  output logic             actOk,
  output logic             rdOk,
  output logic             wrOk,
  output logic             preOk,
  output logic             closeReq,
  output logic             protoErr
);
  localparam int LONGEST = maxOf(maxOf(maxOf(T_RCD, T_RAS), maxOf(T_RP, T_RTP)),
                                 T_BURST + T_WR);
  localparam int CNT_W = $clog2(LONGEST + 1);
  localparam int ACC_W = $clog2(MAX_ACC + 1);

  bankStrobeT stb;
  logic       colReady;
  logic       preReady;
  logic       actReady;

  bank_row_ctrl #(.ROW_W(ROW_W), .MAX_ACC(MAX_ACC), .ACC_W(ACC_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .actIssue(actIssue),
    .rdIssue (rdIssue),
    .wrIssue (wrIssue),
    .preIssue(preIssue),
    .rowAddr (rowAddr),
    .colReady(colReady),
    .preReady(preReady),
    .actReady(actReady),
    .stb     (stb),
    .rowOpen (rowOpen),
    .openRow (openRow),
    .actOk   (actOk),
    .rdOk    (rdOk),
    .wrOk    (wrOk),
    .preOk   (preOk),
    .closeReq(closeReq),
    .protoErr(protoErr)
  );

  bank_timing_dp #(
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RTP(T_RTP),
    .T_WR(T_WR), .T_BURST(T_BURST), .CNT_W(CNT_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .colReady(colReady),
    .preReady(preReady),
    .actReady(actReady)
  );
endmodule

// File: rtl/bank_state_tracker_chk.sv
module bank_state_tracker_chk #(
  parameter int ROW_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             actIssue,
  input logic             rdIssue,
  input logic             wrIssue,
  input logic             preIssue,
  input logic [ROW_W-1:0] rowAddr,
  input logic             rowOpen,
  input logic [ROW_W-1:0] openRow,
  input logic             actOk,
  input logic             rdOk,
  input logic             wrOk,
  input logic             preOk,
  input logic             closeReq,
  input logic             protoErr
);
  AST_ACT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (actIssue && !rowOpen) |=> (rowOpen && openRow == $past(rowAddr))); // R2
  AST_RCD_BLOCKS_COL: assert property (@(posedge clk) disable iff (!rstN)
    (actIssue && !rowOpen) |=> (!rdOk && !wrOk)); // R3
  AST_RAS_BLOCKS_PRE: assert property (@(posedge clk) disable iff (!rstN)
    (actIssue && !rowOpen) |=> !preOk); // R4
  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (preIssue && !actIssue && rowOpen) |=> (!rowOpen && !actOk)); // R5
  AST_COL_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    ((rdIssue || wrIssue) && !actIssue && !preIssue && rowOpen) |=> (!rdOk && !wrOk)); // R6
  AST_ACT_CLEARS_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (actIssue && !rowOpen) |=> !closeReq); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R8
  AST_IDLE_PRE_HARMLESS: assert property (@(posedge clk) disable iff (!rstN)
    (preIssue && !actIssue && !rowOpen) |=> (!rowOpen && $stable(protoErr))); // R9
endmodule

bind bank_state_tracker bank_state_tracker_chk #(.ROW_W(ROW_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .actIssue(actIssue),
  .rdIssue (rdIssue),
  .wrIssue (wrIssue),
  .preIssue(preIssue),
  .rowAddr (rowAddr),
  .rowOpen (rowOpen),
  .openRow (openRow),
  .actOk   (actOk),
  .rdOk    (rdOk),
  .wrOk    (wrOk),
  .preOk   (preOk),
  .closeReq(closeReq),
  .protoErr(protoErr)
);

// File: tb/tb_bank_state_tracker.sv
`timescale 1ns/1ps
module tb_bank_state_tracker;
  localparam int ROW_W = 16;
  localparam int TRCD = 11, TRAS = 28, TRP = 11, TRTP = 6, TWR = 12, TB = 4, MAXA = 16;

  logic clk = 1'b0;
  logic rstN;
  logic actIssue, rdIssue, wrIssue, preIssue;
  logic [ROW_W-1:0] rowAddr;
  logic rowOpen, actOk, rdOk, wrOk, preOk, closeReq, protoErr;
  logic [ROW_W-1:0] openRow;

  always #5 clk = ~clk;

  bank_state_tracker dut (
    .clk(clk), .rstN(rstN), .actIssue(actIssue), .rdIssue(rdIssue),
    .wrIssue(wrIssue), .preIssue(preIssue), .rowAddr(rowAddr),
    .rowOpen(rowOpen), .openRow(openRow), .actOk(actOk), .rdOk(rdOk),
    .wrOk(wrOk), .preOk(preOk), .closeReq(closeReq), .protoErr(protoErr)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model: absolute edge numbers from which each command is legal
  int now;
  bit mOpen;
  logic [ROW_W-1:0] mRow;
  int colAt, preAt, actAt, mAcc;
  bit mErr;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit aLegal(); return !mOpen && actAt <= now + 1; endfunction
  function automatic bit cLegal(); return mOpen && colAt <= now + 1; endfunction
  function automatic bit pLegal(); return mOpen && preAt <= now + 1; endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, now);
    end
  endtask

  task automatic apply(input bit a, input bit r, input bit w, input bit p,
                       input logic [ROW_W-1:0] row);
    if (a) begin
      if (mOpen) mErr = 1;
      else begin
        mOpen = 1; mRow = row; mAcc = 0;
        colAt = imax(colAt, now + TRCD);
        preAt = imax(preAt, now + TRAS);
      end
    end else if (p) begin
      if (mOpen) begin
        mOpen = 0;
        actAt = imax(actAt, now + TRP);
      end
    end else if (r || w) begin
      if (!mOpen) mErr = 1;
      else begin
        if (mAcc < MAXA) mAcc++;
        colAt = imax(colAt, now + TB);
        preAt = imax(preAt, now + (r ? TRTP : TB + TWR));
      end
    end
  endtask

  task automatic checkAll();
    chk("R2 rowOpen", int'(rowOpen), int'(mOpen));
    if (mOpen) chk("R2 openRow", int'(openRow), int'(mRow));
    chk("R5 actOk", int'(actOk), int'(aLegal()));
    chk("R3/R6 rdOk", int'(rdOk), int'(cLegal()));
    chk("R3/R6 wrOk", int'(wrOk), int'(cLegal()));
    chk("R4 preOk", int'(preOk), int'(pLegal()));
    chk("R7 closeReq", int'(closeReq), int'(mOpen && mAcc >= MAXA));
    chk("R8 protoErr", int'(protoErr), int'(mErr));
  endtask

  // Called at a falling edge; the command is taken at the next rising edge
  task automatic drive(input bit a, input bit r, input bit w, input bit p,
                       input logic [ROW_W-1:0] row);
    actIssue = a; rdIssue = r; wrIssue = w; preIssue = p; rowAddr = row;
    @(posedge clk);
    now++;
    apply(a, r, w, p, row);
    @(negedge clk);
    actIssue = 0; rdIssue = 0; wrIssue = 0; preIssue = 0;
    checkAll();
  endtask

  task automatic idle(); drive(0, 0, 0, 0, '0); endtask
  task automatic waitAct(); while (!aLegal()) idle(); endtask
  task automatic waitCol(); while (!cLegal()) idle(); endtask
  task automatic waitPre(); while (!pLegal()) idle(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    rstN = 0; actIssue = 0; rdIssue = 0; wrIssue = 0; preIssue = 0; rowAddr = '0;
    now = 0; mOpen = 0; mRow = '0; colAt = 0; preAt = 0; actAt = 0; mAcc = 0; mErr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1 reset state
    chk("R1 rowOpen", int'(rowOpen), 0);
    chk("R1 actOk", int'(actOk), 1);
    chk("R1 rdOk", int'(rdOk), 0);
    chk("R1 wrOk", int'(wrOk), 0);
    chk("R1 preOk", int'(preOk), 0);
    chk("R1 closeReq", int'(closeReq), 0);
    chk("R1 protoErr", int'(protoErr), 0);

    // R9 precharge on a closed bank
    drive(0, 0, 0, 1, '0);
    chk("R9 stays closed", int'(rowOpen), 0);
    chk("R9 actOk kept", int'(actOk), 1);
    chk("R9 no error", int'(protoErr), 0);

    // Constrained random legal traffic
    for (int i = 0; i < 4000; i++) begin
      int pick = $urandom_range(0, 15);
      if (mOpen && mAcc >= MAXA && pLegal()) drive(0, 0, 0, 1, '0);
      else if (pick < 3 && aLegal()) drive(1, 0, 0, 0, ROW_W'($urandom()));
      else if (pick < 10 && cLegal()) begin
        if ($urandom_range(0, 1) == 0) drive(0, 1, 0, 0, '0);
        else drive(0, 0, 1, 0, '0);
      end
      else if (pick == 10 && pLegal()) drive(0, 0, 0, 1, '0);
      else idle();
    end

    // R7 directed: reach the access cap
    if (mOpen) begin waitPre(); drive(0, 0, 0, 1, '0); end
    waitAct();
    drive(1, 0, 0, 0, 16'h00AB);
    for (int k = 0; k < MAXA; k++) begin
      waitCol();
      chk("R7 below cap", int'(closeReq), 0);
      if (k % 2 == 0) drive(0, 1, 0, 0, '0); else drive(0, 0, 1, 0, '0);
    end
    chk("R7 cap reached", int'(closeReq), 1);
    waitCol();
    drive(0, 1, 0, 0, '0);
    chk("R7 cap holds", int'(closeReq), 1);
    waitPre();
    drive(0, 0, 0, 1, '0);
    chk("R7 dropped on close", int'(closeReq), 0);

    // R10 simultaneous ACTIVATE and READ on a closed bank
    waitAct();
    drive(1, 1, 0, 0, 16'h0123);
    chk("R10 act wins", int'(rowOpen), 1);
    chk("R10 row", int'(openRow), 16'h0123);
    chk("R10 no error", int'(protoErr), 0);
    chk("R10 rcd pending", int'(rdOk), 0);

    // R8 protocol errors
    waitPre();
    drive(0, 0, 0, 1, '0);
    drive(0, 1, 0, 0, '0);
    chk("R8 read closed sets err", int'(protoErr), 1);
    chk("R8 read closed no open", int'(rowOpen), 0);
    waitAct();
    drive(1, 0, 0, 0, 16'h0055);
    drive(1, 0, 0, 0, 16'h0077);
    chk("R8 row kept", int'(openRow), 16'h0055);
    chk("R8 err sticky", int'(protoErr), 1);
    repeat (5) idle();
    chk("R8 err held", int'(protoErr), 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule